// File: doc/BRIEF.md
# Capture Sample Tagger

This block produces a tag for every sample that a state-mode capture writes to memory. The tag reports how much happened between stored samples. It has two counting modes. In state mode it counts the qualified clock states that were seen but not stored. In time mode it counts ticks of a fixed timebase. With the usual 8 ns tick, a 32-bit counter covers well over half a minute at one-tick resolution.

The tag can be referenced in one of two ways. In the first, it is the distance from the previous stored sample: the counter restarts on every store. In the second, it is the distance from the trigger: only the trigger strobe restarts the counter, and stores leave it running. The block can take a store strobe on every clock, so tagging never slows acquisition. The capture logic writes the tag into a memory slot next to its sample.

The counter saturates instead of wrapping. An interval that is too long therefore reads as the largest value the counter can hold, not as a small wrong number.

Top module: `acq_tagger`

## Requirements
- R1: After reset, tag_valid is 0, tag_out is 0 and the internal count is 0.
- R2: With mode_time = 0, the count advances by one on each cycle where qual_stb is 1, and tick_en has no effect on it.
- R3: With mode_time = 1, the count advances by one on each cycle where tick_en is 1, and qual_stb has no effect on it.
- R4: A store_stb in cycle N gives tag_valid = 1 in cycle N+1. In that cycle, tag_out holds the count as it stood at the start of cycle N, which covers the events of the cycles before N since the last restart.
- R5: With ref_trig = 0, a store_stb restarts the count. An event in the store cycle itself counts as the first event of the new interval, so the next count starts at 1.
- R6: With ref_trig = 1, store_stb does not change the count. A trig_stb restarts it, and an event in the trigger cycle counts as 1.
- R7: The count saturates at 2^CNT_W - 1 and never wraps to a smaller value.
- R8: tag_out keeps its value in every cycle that does not follow a store_stb. tag_valid is 0 in those cycles.
- R9: With ref_trig = 0, trig_stb has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick, one cycle per time unit |
| qual_stb | input | 1 | Qualified state seen this cycle |
| store_stb | input | 1 | The sample of this cycle is stored |
| trig_stb | input | 1 | Trigger occurred this cycle |
| mode_time | input | 1 | 0 counts qualified states, 1 counts timebase ticks |
| ref_trig | input | 1 | 0 restarts on each store, 1 restarts only on trigger |
| tag_out | output | CNT_W | Tag of the most recent stored sample |
| tag_valid | output | 1 | High in the cycle after a store |

## Verification
The assertions assume that every strobe is a one-cycle level that is sampled on the clock. They also assume that mode_time and ref_trig can change on any cycle, because the count itself does not depend on how long a mode has been held. The directed stimulus changes mode or reference only right after a flushing store or trigger, so that each expected tag is a small number that can be stated directly. The random phase then drops that restriction and compares against the bench model on every cycle. The bench uses a 6-bit counter so that saturation can be reached in a few dozen ticks.

// File: rtl/acq_tagger.sv
module acq_tagger #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             qual_stb,
  input  logic             store_stb,
  input  logic             trig_stb,
  input  logic             mode_time,
  input  logic             ref_trig,
  output logic [CNT_W-1:0] tag_out,
  output logic             tag_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             inc;
  logic             restart;

  assign inc     = mode_time ? tick_en : qual_stb;
  assign restart = ref_trig ? trig_stb : store_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      tag_out   <= '0;
      tag_valid <= 1'b0;
    end else begin
      tag_valid <= store_stb;
      if (store_stb) tag_out <= cnt;
      if (restart)
        cnt <= {{(CNT_W-1){1'b0}}, inc};
      else if (inc && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end

  assert_valid_follows_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |=> (tag_valid && tag_out == $past(cnt)));
  assert_tag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !store_stb |=> ($stable(tag_out) && !tag_valid));
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!store_stb && !trig_stb) |=> cnt >= $past(cnt));
  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !store_stb && !trig_stb) |=> cnt == CNT_MAX);
  assert_store_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_stb && !ref_trig) |=> cnt <= 1);
  assert_trig_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_stb && ref_trig) |=> cnt <= 1);
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!store_stb && !trig_stb) |=> cnt <= $past(cnt) + 1);
endmodule

// File: tb/acq_tagger_test.sv
module acq_tagger_test;
  localparam int PERIOD = 10;
  localparam int W = 6;
  localparam longint MAXV = 63;

  logic clk = 0, rst_n = 0;
  logic tick_en = 0, qual_stb = 0, store_stb = 0, trig_stb = 0;
  logic mode_time = 0, ref_trig = 0;
  logic [W-1:0] tag_out;
  logic tag_valid;

  int checks = 0, errors = 0;
  string req = "R1";
  longint m_cnt = 0, m_tag = 0;
  bit m_valid = 0;

  acq_tagger #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .qual_stb(qual_stb),
    .store_stb(store_stb), .trig_stb(trig_stb), .mode_time(mode_time),
    .ref_trig(ref_trig), .tag_out(tag_out), .tag_valid(tag_valid));

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    bit inc, rs;
    if (!rst_n) begin
      m_cnt = 0; m_tag = 0; m_valid = 0;
    end else begin
      inc = mode_time ? tick_en : qual_stb;
      rs = ref_trig ? trig_stb : store_stb;
      m_valid = store_stb;
      if (store_stb) m_tag = m_cnt;
      if (rs) m_cnt = inc ? 1 : 0;
      else if (inc && m_cnt < MAXV) m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    checks += 2;
    if (tag_valid !== m_valid) begin
      errors++;
      $display("FAIL %s model tag_valid: actual %0b expected %0b", req, tag_valid, m_valid);
    end
    if (tag_out !== m_tag[W-1:0]) begin
      errors++;
      $display("FAIL %s model tag_out: actual %0d expected %0d", req, tag_out, m_tag);
    end
  end

  task automatic cyc(input bit q, input bit t, input bit s, input bit tr);
    qual_stb = q; tick_en = t; store_stb = s; trig_stb = tr;
    @(negedge clk);
    qual_stb = 0; tick_en = 0; store_stb = 0; trig_stb = 0;
  endtask

  task automatic expect_tag(input string r, input longint exp);
    checks++;
    if (!(tag_valid === 1'b1 && tag_out == exp[W-1:0])) begin
      errors++;
      $display("FAIL %s directed tag: actual %0d (valid %0b) expected %0d", r, tag_out, tag_valid, exp);
    end
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    checks++;
    if (tag_out !== 0 || tag_valid !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %0d/%0b expected 0/0", tag_out, tag_valid);
    end
    rst_n = 1;
    // R2: state mode, ticks ignored
    req = "R2";
    for (int i = 0; i < 5; i++) begin cyc(1, 1, 0, 0); cyc(0, 1, 0, 0); end
    cyc(0, 0, 1, 0);
    expect_tag("R2", 5);
    // R3: time mode, qualifiers ignored
    req = "R3"; mode_time = 1;
    cyc(0, 0, 1, 0);
    for (int i = 0; i < 7; i++) begin cyc(1, 1, 0, 0); cyc(1, 0, 0, 0); end
    cyc(0, 0, 1, 0);
    expect_tag("R3", 7);
    // R4/R5: event in the store cycle opens the next interval
    req = "R5";
    cyc(0, 1, 1, 0);
    expect_tag("R4", 0);
    cyc(0, 0, 1, 0);
    expect_tag("R5", 1);
    cyc(0, 0, 0, 0);
    checks++;
    if (tag_valid !== 0 || tag_out !== 1) begin
      errors++;
      $display("FAIL R8 hold: actual %0d/%0b expected 1/0", tag_out, tag_valid);
    end
    // R9: trigger ignored with store reference
    req = "R9";
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 1); cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    expect_tag("R9", 3);
    // R6: trigger reference
    req = "R6"; ref_trig = 1;
    cyc(0, 1, 0, 1);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    expect_tag("R6", 4);
    cyc(0, 1, 1, 0);
    expect_tag("R6", 4);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    expect_tag("R6", 6);
    cyc(0, 0, 1, 1);
    expect_tag("R6", 6);
    cyc(0, 0, 1, 0);
    expect_tag("R6", 0);
    // R7: saturation
    req = "R7"; ref_trig = 0;
    cyc(0, 0, 1, 0);
    for (int i = 0; i < 70; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    expect_tag("R7", MAXV);
    // random mix against the model
    req = "R4";
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) begin mode_time = $urandom_range(0, 1); ref_trig = $urandom_range(0, 1); end
      cyc($urandom_range(0, 1), $urandom_range(0, 3) != 0,
          $urandom_range(0, 15) == 0, $urandom_range(0, 40) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule